// File: doc/BRIEF.md
# Banked Data Address Generator

This block produces the 12-bit data-space address for an 8-bit controller datapath whose 4096-byte register file is cut into sixteen 256-byte banks. Each cycle it combines the 8-bit file field of the current instruction with one of three address sources. The first is a 4-bit bank register that supplies the upper nibble. The second is a fixed 256-byte access window. The third is one of three 12-bit pointers used for indirect access.

The access window does not sit inside one bank. Its lower half maps to the bottom 128 bytes of bank 0, and its upper half maps to the top 128 bytes of bank 15, where the peripheral registers live. This lets code reach both scratch data and peripherals without touching the bank register. The block also holds the bank register and the three pointers. A pointer can be loaded one byte at a time or as a whole 12-bit literal. Any load becomes visible on the address one clock edge after it is issued.

Top module: `bankaddr_gen`

## Requirements
- R1: After reset, the bank register and all three pointers are zero. With `acc_sel`=1 and file field 0x00 the address is 0x000, and every valid indirect select gives 0x000.
- R2: With `ind_req`=0 and `acc_sel`=1, `eff_addr` = {bank[3:0], file_addr[7:0]}.
- R3: With `ind_req`=0, `acc_sel`=0 and `file_addr` in 0x00..0x7F, `eff_addr` = 0x000 + file_addr, whatever the bank register holds.
- R4: With `ind_req`=0, `acc_sel`=0 and `file_addr` in 0x80..0xFF, `eff_addr` = 0xF00 + file_addr, which is the range 0xF80..0xFFF.
- R5: `bank_we`=1 at a clock edge loads `bank_wdata[3:0]` into the bank register. Bits 7:4 of `bank_wdata` are ignored. The new value shows on `eff_addr` after that edge.
- R6: `ptr_op`=3 loads `ptr_wdata_full[11:0]` into the pointer chosen by `ptr_wsel`, visible after the edge.
- R7: `ptr_op`=1 loads `ptr_wdata_byte` into bits 7:0 of the chosen pointer and leaves bits 11:8 unchanged.
- R8: `ptr_op`=2 loads `ptr_wdata_byte[3:0]` into bits 11:8 of the chosen pointer. Bits 7:4 of the byte are dropped, and bits 7:0 of the pointer are unchanged. `ptr_op`=0 does nothing.
- R9: With `ind_req`=1 and `ind_sel` in 0..2, `eff_addr` equals pointer `ind_sel`. `acc_sel`, `file_addr` and the bank register have no effect.
- R10: `ind_sel`=3 with `ind_req`=1 gives `eff_addr`=0x000. A pointer load with `ptr_wsel`=3 changes no pointer.
- R11: A pointer load changes only the pointer named by `ptr_wsel`. The other two keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| file_addr | input | 8 | File field of the instruction |
| acc_sel | input | 1 | 1: bank register addressing; 0: access window |
| ind_req | input | 1 | 1: address comes from a pointer |
| ind_sel | input | 2 | Pointer used for indirect access (0..2) |
| bank_we | input | 1 | Load the bank register |
| bank_wdata | input | 8 | Bank register write data (low nibble used) |
| ptr_op | input | 2 | Pointer load: 0 none, 1 low byte, 2 high byte, 3 full literal |
| ptr_wsel | input | 2 | Pointer to load (0..2) |
| ptr_wdata_byte | input | 8 | Byte written by low- or high-byte loads |
| ptr_wdata_full | input | 12 | Literal written by a full load |
| eff_addr | output | 12 | Effective data address |

## Verification
The bench sweeps every combination of bank value and file field in both direct modes. This catches the usual error of treating the access window as a plain offset into bank 0 or bank 15: such a design would return the wrong half at the 0x7F/0x80 boundary. Junk is placed in the unused upper nibbles of the bank data and the high-byte data, so a design that keeps those bits would show them on the address. The byte-wise pointer loads are checked against all three pointers. A load that overwrites the wrong half, or lands on a neighbouring pointer, would change an address that must stay fixed. The out-of-range select code 3 is used for both reads and writes to show that it addresses nothing.

// File: rtl/bankaddr_pkg.sv
package bankaddr_pkg;
  typedef enum logic [1:0] {
    PTR_NOP  = 2'd0,
    PTR_LO   = 2'd1,
    PTR_HI   = 2'd2,
    PTR_FULL = 2'd3
  } ptr_op_e;
endpackage

// File: rtl/bankaddr_rst_sync.sv
module bankaddr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/bankaddr_bank_reg.sv
module bankaddr_bank_reg #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [BANK_W-1:0] bank_q
);
  logic [BANK_W-1:0] bank_nxt;

  always_comb begin
    bank_nxt = bank_q;
    if (we) bank_nxt = wdata[BANK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) bank_q <= '0;
    else if (we) bank_q <= bank_nxt;
  end
endmodule

// File: rtl/bankaddr_ptr_file.sv
module bankaddr_ptr_file
  import bankaddr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int FILE_W  = 8,
  parameter int NUM_PTR = 3,
  parameter int PSEL_W  = 2
) (
  input  logic                            clk,
  input  logic                            rst_q,
  input  logic [1:0]                      op,
  input  logic [PSEL_W-1:0]               wsel,
  input  logic [FILE_W-1:0]               wbyte,
  input  logic [ADDR_W-1:0]               wfull,
  output logic [NUM_PTR-1:0][ADDR_W-1:0]  ptr_q
);
  localparam int HI_W = ADDR_W - FILE_W;

  ptr_op_e op_e;
  assign op_e = ptr_op_e'(op);

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic              hit;
    logic [ADDR_W-1:0] nxt;

    assign hit = (op_e != PTR_NOP) && (wsel == PSEL_W'(i));

    always_comb begin
      nxt = ptr_q[i];
      case (op_e)
        PTR_LO:   nxt[FILE_W-1:0]      = wbyte;
        PTR_HI:   nxt[ADDR_W-1:FILE_W] = wbyte[HI_W-1:0];
        PTR_FULL: nxt                  = wfull;
        default:  nxt                  = ptr_q[i];
      endcase
    end

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) ptr_q[i] <= '0;
      else if (hit) ptr_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/bankaddr_mux.sv
module bankaddr_mux #(
  parameter int ADDR_W  = 12,
  parameter int FILE_W  = 8,
  parameter int NUM_PTR = 3,
  parameter int PSEL_W  = 2
) (
  input  logic [FILE_W-1:0]              file_addr,
  input  logic                           acc_sel,
  input  logic                           ind_req,
  input  logic [PSEL_W-1:0]              ind_sel,
  input  logic [ADDR_W-FILE_W-1:0]       bank_q,
  input  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q,
  output logic [ADDR_W-1:0]              eff_addr
);
  localparam int HI_W = ADDR_W - FILE_W;

  logic [ADDR_W-1:0] ind_addr;
  logic [HI_W-1:0]   win_hi;

  always_comb begin
    ind_addr = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (ind_sel == PSEL_W'(i)) ind_addr = ptr_q[i];
    end
  end

  // Window top half sits in the last bank, bottom half in bank 0
  assign win_hi = file_addr[FILE_W-1] ? '1 : '0;

  always_comb begin
    if (ind_req)      eff_addr = ind_addr;
    else if (acc_sel) eff_addr = {bank_q, file_addr};
    else              eff_addr = {win_hi, file_addr};
  end
endmodule

// File: rtl/bankaddr_gen.sv
module bankaddr_gen #(
  parameter int ADDR_W  = 12,
  parameter int FILE_W  = 8,
  parameter int NUM_PTR = 3,
  parameter int PSEL_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FILE_W-1:0]    file_addr,
  input  logic                 acc_sel,
  input  logic                 ind_req,
  input  logic [PSEL_W-1:0]    ind_sel,
  input  logic                 bank_we,
  input  logic [FILE_W-1:0]    bank_wdata,
  input  logic [1:0]           ptr_op,
  input  logic [PSEL_W-1:0]    ptr_wsel,
  input  logic [FILE_W-1:0]    ptr_wdata_byte,
  input  logic [ADDR_W-1:0]    ptr_wdata_full,
  output logic [ADDR_W-1:0]    eff_addr
);
  localparam int BANK_W = ADDR_W - FILE_W;

  logic                           rst_q;
  logic [BANK_W-1:0]              bank_q;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q;

  bankaddr_rst_sync i_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  bankaddr_bank_reg #(.DATA_W(FILE_W), .BANK_W(BANK_W)) i_bank (
    .clk    (clk),
    .rst_q  (rst_q),
    .we     (bank_we),
    .wdata  (bank_wdata),
    .bank_q (bank_q)
  );

  bankaddr_ptr_file #(
    .ADDR_W(ADDR_W), .FILE_W(FILE_W), .NUM_PTR(NUM_PTR), .PSEL_W(PSEL_W)
  ) i_ptrs (
    .clk   (clk),
    .rst_q (rst_q),
    .op    (ptr_op),
    .wsel  (ptr_wsel),
    .wbyte (ptr_wdata_byte),
    .wfull (ptr_wdata_full),
    .ptr_q (ptr_q)
  );

  bankaddr_mux #(
    .ADDR_W(ADDR_W), .FILE_W(FILE_W), .NUM_PTR(NUM_PTR), .PSEL_W(PSEL_W)
  ) i_mux (
    .file_addr (file_addr),
    .acc_sel   (acc_sel),
    .ind_req   (ind_req),
    .ind_sel   (ind_sel),
    .bank_q    (bank_q),
    .ptr_q     (ptr_q),
    .eff_addr  (eff_addr)
  );
endmodule

// File: rtl/bankaddr_chk.sv
module bankaddr_chk #(
  parameter int ADDR_W  = 12,
  parameter int FILE_W  = 8,
  parameter int NUM_PTR = 3,
  parameter int PSEL_W  = 2
) (
  input logic                           clk,
  input logic                           rst_q,
  input logic [FILE_W-1:0]              file_addr,
  input logic                           acc_sel,
  input logic                           ind_req,
  input logic [PSEL_W-1:0]              ind_sel,
  input logic                           bank_we,
  input logic [FILE_W-1:0]              bank_wdata,
  input logic [1:0]                     ptr_op,
  input logic [PSEL_W-1:0]              ptr_wsel,
  input logic [FILE_W-1:0]              ptr_wdata_byte,
  input logic [ADDR_W-1:0]              ptr_wdata_full,
  input logic [ADDR_W-FILE_W-1:0]       bank_q,
  input logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q,
  input logic [ADDR_W-1:0]              eff_addr
);
  localparam int HI_W = ADDR_W - FILE_W;

  // R2
  banked_addr_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!ind_req && acc_sel) |-> (eff_addr == {bank_q, file_addr}));

  // R3
  acc_low_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!ind_req && !acc_sel && !file_addr[FILE_W-1]) |->
      (eff_addr[ADDR_W-1:FILE_W] == '0 && eff_addr[FILE_W-1:0] == file_addr));

  // R4
  acc_high_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!ind_req && !acc_sel && file_addr[FILE_W-1]) |->
      (eff_addr[ADDR_W-1:FILE_W] == '1 && eff_addr[FILE_W-1:0] == file_addr));

  // R5
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_q)
    bank_we |=> (bank_q == $past(bank_wdata[HI_W-1:0])));

  // R10
  ind_bad_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ind_req && ind_sel >= PSEL_W'(NUM_PTR)) |-> (eff_addr == '0));

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_p
    // R9
    ind_addr_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (ind_req && ind_sel == PSEL_W'(i)) |-> (eff_addr == ptr_q[i]));

    // R6
    full_load_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (ptr_op == 2'd3 && ptr_wsel == PSEL_W'(i)) |=> (ptr_q[i] == $past(ptr_wdata_full)));

    // R7
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (ptr_op == 2'd1 && ptr_wsel == PSEL_W'(i)) |=>
        (ptr_q[i][FILE_W-1:0] == $past(ptr_wdata_byte) &&
         ptr_q[i][ADDR_W-1:FILE_W] == $past(ptr_q[i][ADDR_W-1:FILE_W])));

    // R8
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (ptr_op == 2'd2 && ptr_wsel == PSEL_W'(i)) |=>
        (ptr_q[i][ADDR_W-1:FILE_W] == $past(ptr_wdata_byte[HI_W-1:0]) &&
         ptr_q[i][FILE_W-1:0] == $past(ptr_q[i][FILE_W-1:0])));

    // R11
    untouched_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (ptr_op == 2'd0 || ptr_wsel != PSEL_W'(i)) |=> $stable(ptr_q[i]));
  end
endmodule

bind bankaddr_gen bankaddr_chk #(
  .ADDR_W(ADDR_W), .FILE_W(FILE_W), .NUM_PTR(NUM_PTR), .PSEL_W(PSEL_W)
) i_chk (.*);

// File: tb/test_bankaddr_gen.sv
`timescale 1ns/1ps
module test_bankaddr_gen;
  logic        clk;
  logic        rst_n;
  logic [7:0]  file_addr;
  logic        acc_sel;
  logic        ind_req;
  logic [1:0]  ind_sel;
  logic        bank_we;
  logic [7:0]  bank_wdata;
  logic [1:0]  ptr_op;
  logic [1:0]  ptr_wsel;
  logic [7:0]  ptr_wdata_byte;
  logic [11:0] ptr_wdata_full;
  logic [11:0] eff_addr;

  int n_chk;
  int n_fail;
  int cycles;
  logic [11:0] model [3];

  bankaddr_gen i_bankaddr_gen (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual hung run, expected completion");
        finish_run();
      end
    end
  end

  task automatic chk(input logic [11:0] got, input logic [11:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", tag, got, exp);
    end
  endtask

  task automatic probe(input logic ind, input logic [1:0] isel, input logic acc,
                       input logic [7:0] f, input logic [11:0] exp, input string tag);
    @(negedge clk);
    ind_req = ind; ind_sel = isel; acc_sel = acc; file_addr = f;
    #1;
    chk(eff_addr, exp, tag);
  endtask

  task automatic wr_bank(input logic [7:0] d);
    @(negedge clk);
    bank_we = 1'b1; bank_wdata = d;
    @(negedge clk);
    bank_we = 1'b0; bank_wdata = 8'hA5;
  endtask

  task automatic wr_ptr(input logic [1:0] op, input logic [1:0] sel,
                        input logic [7:0] b, input logic [11:0] full);
    @(negedge clk);
    ptr_op = op; ptr_wsel = sel; ptr_wdata_byte = b; ptr_wdata_full = full;
    @(negedge clk);
    ptr_op = 2'd0; ptr_wdata_byte = 8'h5A; ptr_wdata_full = 12'hC3C;
    if (sel < 2'd3) begin
      case (op)
        2'd1: model[sel] = {model[sel][11:8], b};
        2'd2: model[sel] = {b[3:0], model[sel][7:0]};
        2'd3: model[sel] = full;
        default: ;
      endcase
    end
  endtask

  task automatic check_ptrs(input string tag);
    for (int p = 0; p < 3; p++) begin
      probe(1'b1, 2'(p), 1'(p & 1), 8'(p * 37 + 129), model[p], tag);
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    file_addr = 8'h00; acc_sel = 1'b0; ind_req = 1'b0; ind_sel = 2'd0;
    bank_we = 1'b0; bank_wdata = 8'h00;
    ptr_op = 2'd0; ptr_wsel = 2'd0; ptr_wdata_byte = 8'h00; ptr_wdata_full = 12'h000;
    for (int p = 0; p < 3; p++) model[p] = 12'h000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    probe(1'b0, 2'd0, 1'b1, 8'h00, 12'h000, "R1 bank after reset");
    for (int p = 0; p < 3; p++) probe(1'b1, 2'(p), 1'b1, 8'hFF, 12'h000, "R1 pointer after reset");

    // R2..R5 exhaustive bank x file sweep, junk in upper nibble of bank data
    for (int b = 0; b < 16; b++) begin
      wr_bank({4'(15 - b), 4'(b)});
      probe(1'b0, 2'd0, 1'b1, 8'h3C, {4'(b), 8'h3C}, "R5 bank load next cycle");
      for (int f = 0; f < 256; f++) begin
        probe(1'b0, 2'd3, 1'b1, 8'(f), {4'(b), 8'(f)}, "R2 banked address");
        if (f < 128) probe(1'b0, 2'd3, 1'b0, 8'(f), 12'(f), "R3 window low half");
        else         probe(1'b0, 2'd3, 1'b0, 8'(f), 12'(f) + 12'hF00, "R4 window high half");
      end
    end

    // R6 full loads
    wr_ptr(2'd3, 2'd0, 8'h00, 12'h123);
    wr_ptr(2'd3, 2'd1, 8'h00, 12'hABC);
    wr_ptr(2'd3, 2'd2, 8'h00, 12'h5A5);
    check_ptrs("R6 full load");
    // R9 bank/acc/file ignored
    wr_bank(8'h07);
    probe(1'b1, 2'd1, 1'b0, 8'h80, 12'hABC, "R9 indirect ignores window");
    probe(1'b1, 2'd1, 1'b1, 8'h01, 12'hABC, "R9 indirect ignores bank");

    // R7 low byte load, R11 others untouched
    wr_ptr(2'd1, 2'd1, 8'h3C, 12'hFFF);
    check_ptrs("R7 R11 low byte load");
    // R8 high byte load with junk upper nibble
    wr_ptr(2'd2, 2'd2, 8'hE9, 12'hFFF);
    check_ptrs("R8 R11 high byte load");
    wr_ptr(2'd2, 2'd0, 8'hF0, 12'h000);
    check_ptrs("R8 high byte drops bits 7:4");

    // R10 bad select on write and read
    wr_ptr(2'd3, 2'd3, 8'hFF, 12'hFFF);
    check_ptrs("R10 write select 3 ignored");
    probe(1'b1, 2'd3, 1'b1, 8'hFF, 12'h000, "R10 indirect select 3");

    // R6 R11 sweep of literal loads
    for (int p = 0; p < 3; p++) begin
      for (int v = 0; v < 4096; v += 37) begin
        wr_ptr(2'd3, 2'(p), 8'h00, 12'(v));
        check_ptrs("R6 R11 literal sweep");
      end
    end

    finish_run();
  end
endmodule